// File: doc/BRIEF.md
# Encoded Interrupt-Level Mask Unit

This block watches two external 4-bit interrupt-level codes, set A (pins 3..0) and set B (pins 7..4). For each set it decides whether the code now present may raise an interrupt request. Each input passes through a two-flop synchroniser. The block then registers a request flag and the latched code for each set, so downstream arbitration sees a clean pair of values.

Each set has two levels of masking. A coarse per-set mask arrives as an input and blocks the whole set while it is high. A fine per-code mask sits in a 32-bit register with one bit for every code of every set. Software sets fine mask bits by writing ones at the mask address. It releases them by writing ones at a separate clear address. A plain register bus gives access to both: address, write strobe, write data and combinational read data.

Top module: `irl_mask_unit`

## Requirements
- R1: After reset all fine mask bits are 0, both request outputs are low and both latched code outputs read 15 (all ones).
- R2: The fine mask bit for code c of set A is bit 31-c of the mask register, and for code c of set B it is bit 15-c. Setting one code's bit affects no other code.
- R3: A write at the mask address (address 0) sets every mask bit whose write-data bit is 1. Bits written as 0 keep their value, and a read there returns 1 for each masked code.
- R4: A write at the clear address (address 1) clears every mask bit whose write-data bit is 1. Bits written as 0 keep their value, and a read of the clear address returns 0.
- R5: Bits 16 and 0 of the mask register always read 0, even after ones are written to them.
- R6: While coarse_mask_i[0] is high, set A raises no request, and coarse_mask_i[1] does the same for set B, whatever the fine mask bits hold. A change of the coarse mask is seen at the outputs after the next clock edge.
- R7: Code 15 never produces a request, even with every mask clear.
- R8: A request is high when the synchronised code is not 15, the set's coarse mask is low and the fine bit for that code is 0. A code held stable before clock edge n shows on req and code outputs after edge n+2, and not after edge n+1.
- R9: A mask write and a request evaluation at the same clock edge use the old mask value. The new mask affects the request from the following edge.
- R10: The code outputs carry the synchronised code of each set, with the same timing as the request outputs.
- R11: Writes to addresses other than 0 and 1 change no mask bit, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irl_a_i | input | 4 | Encoded level code, set A (pins 3..0) |
| irl_b_i | input | 4 | Encoded level code, set B (pins 7..4) |
| coarse_mask_i | input | 2 | Per-set coarse mask: bit 0 set A, bit 1 set B |
| bus_addr_i | input | 2 | Register word address: 0 mask, 1 clear |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed register |
| req_a_o | output | 1 | Masked request flag, set A |
| req_b_o | output | 1 | Masked request flag, set B |
| code_a_o | output | 4 | Latched synchronised code, set A |
| code_b_o | output | 4 | Latched synchronised code, set B |

## Verification
A wrong bit in the mask register shows at the read port in the cycle after the write that caused it. For a code mapped to that bit, it also shows on the request flag one edge later, so each directed test holds a code and reads the register back. A wrong index in the code-to-bit mapping only shows when that particular code is present. For that reason the tests cover the first and last codes of both halves and a neighbour of the masked code. Faults in the synchroniser depth or in the stage where the old or new mask is used show as a request that moves one edge early or late. The bench samples the edge before and the edge after each expected change.

// File: rtl/irl_mask_pkg.sv
package irl_mask_pkg;

  typedef enum int {SET_A = 0, SET_B = 1} irl_set_e;

  localparam int NUM_SETS = 2;

  // Register bit that masks code `code` of set `set`; the upper half serves
  // set A, the lower half set B, and the index falls as the code rises.
  function automatic int mask_bit_idx(input int set, input int code, input int ncodes);
    int top;
    top = (set == SET_A) ? (2 * ncodes - 1) : (ncodes - 1);
    return top - code;
  endfunction

  // A bit is writable unless it is the lowest bit of a half (the idle code slot).
  function automatic bit bit_writable(input int idx, input int ncodes);
    return (idx % ncodes) != 0;
  endfunction

endpackage

// File: rtl/irl_sync.sv
module irl_sync #(
  parameter int W    = 4,
  parameter logic [W-1:0] IDLE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= IDLE;
      stab_q <= IDLE;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/irl_mask_regs.sv
module irl_mask_regs
  import irl_mask_pkg::*;
#(
  parameter int CODE_W    = 4,
  parameter int ADDR_W    = 2,
  parameter int MASK_ADDR = 0,
  parameter int CLR_ADDR  = 1,
  localparam int NCODES   = 1 << CODE_W,
  localparam int REG_W    = 2 * NCODES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [REG_W-1:0]  mask_o,
  output logic              set_evt_o,
  output logic              clr_evt_o
);
  logic [REG_W-1:0] wmask;
  logic [REG_W-1:0] mask_q;
  logic [REG_W-1:0] mask_d;
  logic [REG_W-1:0] set_bits;
  logic [REG_W-1:0] clr_bits;

  for (genvar i = 0; i < REG_W; i++) begin : g_wmask
    assign wmask[i] = bit_writable(i, NCODES);
  end

  assign set_evt_o = wr_i && (addr_i == ADDR_W'(MASK_ADDR));
  assign clr_evt_o = wr_i && (addr_i == ADDR_W'(CLR_ADDR));
  assign set_bits  = set_evt_o ? (wdata_i & wmask) : '0;
  assign clr_bits  = clr_evt_o ? (wdata_i & wmask) : '0;

  always_comb begin
    mask_d = (mask_q | set_bits) & ~clr_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign mask_o  = mask_q;
  assign rdata_o = (addr_i == ADDR_W'(MASK_ADDR)) ? mask_q : '0;
endmodule

// File: rtl/irl_gate.sv
module irl_gate
  import irl_mask_pkg::*;
#(
  parameter int CODE_W  = 4,
  parameter int SET_IDX = 0,
  localparam int NCODES = 1 << CODE_W,
  localparam int REG_W  = 2 * NCODES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_i,
  input  logic              coarse_i,
  input  logic [REG_W-1:0]  mask_i,
  output logic              req_o,
  output logic [CODE_W-1:0] code_o
);
  logic [NCODES-1:0] per_code;
  logic              fine_hit;
  logic              idle_code;
  logic              req_d;
  logic              req_q;
  logic [CODE_W-1:0] code_q;

  // Gather this set's bits into code order.
  for (genvar c = 0; c < NCODES; c++) begin : g_pick
    localparam int BIT = mask_bit_idx(SET_IDX, c, NCODES);
    assign per_code[c] = mask_i[BIT];
  end

  assign fine_hit  = per_code[code_i];
  assign idle_code = &code_i;
  assign req_d     = !idle_code && !coarse_i && !fine_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      code_q <= '1;
    end else begin
      req_q  <= req_d;
      code_q <= code_i;
    end
  end

  assign req_o  = req_q;
  assign code_o = code_q;
endmodule

// File: rtl/irl_mask_unit.sv
module irl_mask_unit
  import irl_mask_pkg::*;
#(
  parameter int CODE_W    = 4,
  parameter int ADDR_W    = 2,
  parameter int MASK_ADDR = 0,
  parameter int CLR_ADDR  = 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [CODE_W-1:0]              irl_a_i,
  input  logic [CODE_W-1:0]              irl_b_i,
  input  logic [1:0]                     coarse_mask_i,
  input  logic [ADDR_W-1:0]              bus_addr_i,
  input  logic                           bus_wr_i,
  input  logic [2*(1<<CODE_W)-1:0]       bus_wdata_i,
  output logic [2*(1<<CODE_W)-1:0]       bus_rdata_o,
  output logic                           req_a_o,
  output logic                           req_b_o,
  output logic [CODE_W-1:0]              code_a_o,
  output logic [CODE_W-1:0]              code_b_o
);
  localparam int NCODES = 1 << CODE_W;
  localparam int REG_W  = 2 * NCODES;

  logic [REG_W-1:0]  mask_w;
  logic              set_evt_w;
  logic              clr_evt_w;
  logic [CODE_W-1:0] raw_code [NUM_SETS];
  logic [CODE_W-1:0] sync_code[NUM_SETS];
  logic [CODE_W-1:0] out_code [NUM_SETS];
  logic              out_req  [NUM_SETS];

  assign raw_code[SET_A] = irl_a_i;
  assign raw_code[SET_B] = irl_b_i;

  irl_mask_regs #(
    .CODE_W(CODE_W), .ADDR_W(ADDR_W), .MASK_ADDR(MASK_ADDR), .CLR_ADDR(CLR_ADDR)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .addr_i(bus_addr_i), .wr_i(bus_wr_i),
    .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o), .mask_o(mask_w),
    .set_evt_o(set_evt_w), .clr_evt_o(clr_evt_w)
  );

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    irl_sync #(.W(CODE_W), .IDLE({CODE_W{1'b1}})) sync_i (
      .clk(clk), .rst_n(rst_n), .d_i(raw_code[s]), .q_o(sync_code[s])
    );
    irl_gate #(.CODE_W(CODE_W), .SET_IDX(s)) gate_i (
      .clk(clk), .rst_n(rst_n), .code_i(sync_code[s]), .coarse_i(coarse_mask_i[s]),
      .mask_i(mask_w), .req_o(out_req[s]), .code_o(out_code[s])
    );
  end

  assign req_a_o  = out_req[SET_A];
  assign req_b_o  = out_req[SET_B];
  assign code_a_o = out_code[SET_A];
  assign code_b_o = out_code[SET_B];
endmodule

// File: rtl/irl_mask_unit_chk.sv
module irl_mask_unit_chk #(
  parameter int CODE_W    = 4,
  parameter int ADDR_W    = 2,
  parameter int MASK_ADDR = 0,
  parameter int CLR_ADDR  = 1,
  localparam int NCODES   = 1 << CODE_W,
  localparam int REG_W    = 2 * NCODES
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        coarse_mask_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_wr_i,
  input logic [REG_W-1:0]  bus_wdata_i,
  input logic [REG_W-1:0]  bus_rdata_o,
  input logic              req_a_o,
  input logic              req_b_o,
  input logic [CODE_W-1:0] code_a_o,
  input logic [CODE_W-1:0] code_b_o,
  input logic [REG_W-1:0]  mask_w
);
  logic [REG_W-1:0] reserved;
  assign reserved = REG_W'(1) | (REG_W'(1) << NCODES);

  // R7
  idle_code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&code_a_o) |-> !req_a_o) and ((&code_b_o) |-> !req_b_o));

  // R6
  coarse_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(coarse_mask_i[0]) |-> !req_a_o) and ($past(coarse_mask_i[1]) |-> !req_b_o));

  // R5
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_i == ADDR_W'(MASK_ADDR)) |-> ((bus_rdata_o & reserved) == '0));

  // R4
  clear_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_i == ADDR_W'(CLR_ADDR)) |-> (bus_rdata_o == '0));

  // R3
  set_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == ADDR_W'(MASK_ADDR)) |=>
      (mask_w == ($past(mask_w) | ($past(bus_wdata_i) & ~reserved))));

  // R11
  idle_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr_i) |=> $stable(mask_w));
endmodule

bind irl_mask_unit irl_mask_unit_chk #(
  .CODE_W(CODE_W), .ADDR_W(ADDR_W), .MASK_ADDR(MASK_ADDR), .CLR_ADDR(CLR_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .coarse_mask_i(coarse_mask_i), .bus_addr_i(bus_addr_i),
  .bus_wr_i(bus_wr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
  .req_a_o(req_a_o), .req_b_o(req_b_o), .code_a_o(code_a_o), .code_b_o(code_b_o),
  .mask_w(mask_w)
);

// File: tb/irl_mask_unit_tb_top.sv
`timescale 1ns/1ps
module irl_mask_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  irl_a = 4'hF;
  logic [3:0]  irl_b = 4'hF;
  logic [1:0]  coarse = 2'b00;
  logic [1:0]  addr = 2'd0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        req_a, req_b;
  logic [3:0]  code_a, code_b;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irl_mask_unit dut_i (
    .clk(clk), .rst_n(rst_n), .irl_a_i(irl_a), .irl_b_i(irl_b),
    .coarse_mask_i(coarse), .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .req_a_o(req_a), .req_b_o(req_b),
    .code_a_o(code_a), .code_b_o(code_b)
  );

  // Bit positions from the requirements: set A code c -> 31-c, set B code c -> 15-c.
  function automatic logic [31:0] bit_a(input int c); return 32'h1 << (31 - c); endfunction
  function automatic logic [31:0] bit_b(input int c); return 32'h1 << (15 - c); endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr = 1'b1; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; wdata = '0; addr = 2'd0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
    addr = 2'd0;
    #1;
  endtask

  task automatic set_codes(input logic [3:0] a, input logic [3:0] b);
    @(negedge clk);
    irl_a = a; irl_b = b;
    edges(3);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_read(2'd0, d);
    check(d == 32'h0, "R1 mask", d, 32'h0);
    check(req_a == 1'b0 && req_b == 1'b0, "R1 req", {req_a, req_b}, 0);
    check(code_a == 4'hF && code_b == 4'hF, "R1 code", {code_a, code_b}, 32'hFF);
  endtask

  task automatic t_idle();
    set_codes(4'hF, 4'hF);
    check(!req_a && !req_b, "R7 idle code", {req_a, req_b}, 0);
  endtask

  task automatic t_latency();
    @(negedge clk);
    irl_a = 4'd3; irl_b = 4'd9;
    edges(2);
    check(req_a == 1'b0, "R8 not early", req_a, 0);
    edges(1);
    check(req_a && req_b, "R8 request", {req_a, req_b}, 32'h3);
    check(code_a == 4'd3 && code_b == 4'd9, "R10 codes", {code_a, code_b}, 32'h39);
  endtask

  task automatic t_set();
    logic [31:0] d;
    bus_write(2'd0, bit_a(3));
    bus_read(2'd0, d);
    check(d == bit_a(3), "R3 set", d, bit_a(3));
    edges(1);
    check(!req_a && req_b, "R2 A code3 masked", {req_a, req_b}, 32'h1);
    bus_write(2'd0, 32'h0);
    bus_read(2'd0, d);
    check(d == bit_a(3), "R3 zero write", d, bit_a(3));
    bus_write(2'd0, bit_b(8));
    edges(1);
    check(req_b == 1'b1, "R2 neighbour unaffected", req_b, 1);
    bus_write(2'd0, bit_b(9));
    edges(1);
    check(req_b == 1'b0, "R2 B code9 masked", req_b, 0);
    bus_read(2'd0, d);
    check(d == (bit_a(3) | bit_b(8) | bit_b(9)), "R3 accumulate", d, bit_a(3) | bit_b(8) | bit_b(9));
  endtask

  task automatic t_clear();
    logic [31:0] d;
    bus_write(2'd1, bit_a(3));
    edges(1);
    check(req_a == 1'b1, "R4 clear unmask", req_a, 1);
    bus_write(2'd1, 32'h0);
    bus_read(2'd0, d);
    check(d == (bit_b(8) | bit_b(9)), "R4 zero clear", d, bit_b(8) | bit_b(9));
    bus_read(2'd1, d);
    check(d == 32'h0, "R4 clear reads zero", d, 0);
    bus_write(2'd1, 32'hFFFF_FFFF);
    bus_read(2'd0, d);
    check(d == 32'h0, "R4 clear all", d, 0);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    bus_write(2'd0, 32'hFFFF_FFFF);
    bus_read(2'd0, d);
    check(d == 32'hFFFE_FFFE, "R5 reserved bits", d, 32'hFFFE_FFFE);
    bus_write(2'd1, 32'hFFFF_FFFF);
  endtask

  task automatic t_edges_of_range();
    set_codes(4'd14, 4'd0);
    check(req_a && req_b, "R8 codes 14/0 accepted", {req_a, req_b}, 32'h3);
    bus_write(2'd0, bit_a(14) | bit_b(0));
    edges(1);
    check(!req_a && !req_b, "R2 bits 17 and 15", {req_a, req_b}, 0);
    bus_write(2'd1, 32'hFFFF_FFFF);
    set_codes(4'd3, 4'd9);
  endtask

  task automatic t_coarse();
    @(negedge clk); coarse = 2'b01;
    edges(1);
    check(!req_a && req_b, "R6 coarse A", {req_a, req_b}, 32'h1);
    @(negedge clk); coarse = 2'b10;
    edges(1);
    check(req_a && !req_b, "R6 coarse B", {req_a, req_b}, 32'h2);
    @(negedge clk); coarse = 2'b00;
    edges(1);
    check(req_a && req_b, "R6 coarse released", {req_a, req_b}, 32'h3);
  endtask

  task automatic t_same_edge();
    @(negedge clk);
    addr = 2'd0; wr = 1'b1; wdata = bit_a(3);
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; wdata = '0;
    check(req_a == 1'b1, "R9 old mask used", req_a, 1);
    edges(1);
    check(req_a == 1'b0, "R9 new mask next edge", req_a, 0);
    bus_write(2'd1, 32'hFFFF_FFFF);
    edges(1);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bus_write(2'd2, 32'hFFFF_FFFF);
    bus_write(2'd3, 32'hFFFF_FFFF);
    bus_read(2'd0, d);
    check(d == 32'h0, "R11 mask untouched", d, 0);
    bus_read(2'd2, d);
    check(d == 32'h0, "R11 reads zero", d, 0);
    edges(1);
    check(req_a && req_b, "R11 requests unchanged", {req_a, req_b}, 32'h3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_latency();
    t_set();
    t_clear();
    t_reserved();
    t_edges_of_range();
    t_coarse();
    t_same_edge();
    t_unmapped();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule